// File: doc/BRIEF.md
# Flag-Setting Eight-Function ALU

This block is a purely combinational arithmetic and logic unit for a small 8-bit processor. It takes two operands and a 5-bit operation code and produces a result byte together with a carry flag and a zero flag. Addition, subtraction, increment and the two fused variants (sum plus one, difference minus one) share a single adder. The adder's second operand can be inverted or forced to zero, and its carry-in is selectable.

A control decoder turns the operation code into a small set of strobes. A datapath holds the adder, the bitwise AND, and a four-way result selector. Its four sources are the adder, the AND, operand A and operand B. Capturing the flags in registers and choosing the operands are left to the surrounding processor.

Top module: `flag_alu`

## Requirements
- R1: Code 0 (add) gives result = (A + B) mod 256 and carry = bit 8 of the 9-bit sum A + B.
- R2: Code 4 (subtract) gives result = (A - B) mod 256 and carry = bit 8 of A + ~B + 1, so carry is 1 exactly when A >= B (no borrow).
- R3: Code 2 passes A and code 3 passes B to the result unchanged, with carry 0.
- R4: Code 1 gives result = A AND B, with carry always 0.
- R5: Code 6 gives result = (A + B + 1) mod 256, with carry = bit 8 of A + B + 1.
- R6: Code 5 gives result = (A + 1) mod 256, ignoring B, with carry 1 exactly when A = 255.
- R7: Code 7 gives result = (A - B - 1) mod 256 and carry = bit 8 of A + ~B, so carry is 1 exactly when A > B.
- R8: For every code, the zero flag is 1 exactly when the 8-bit result is 0x00.
- R9: Codes 8 to 31 behave as pass A: result = A, carry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| opSel | input | 5 | Operation code |
| result | output | 8 | Selected result |
| carryOut | output | 1 | Carry / no-borrow flag |
| zeroOut | output | 1 | Result-is-zero flag |

## Verification
Each adder-based code is tried with operands that stay in range and with operands that wrap past 255 or below 0. These pairs tell a correct carry-in and operand inversion apart from an off-by-one and from a swapped carry sense. Equal operands in subtraction and in subtract-minus-one separate the A >= B and A > B carry rules. AND and the pass codes are given operand pairs whose results differ, so that a wrong selector source shows up, and some pairs make the result zero to exercise the zero flag. All unused codes are swept with a pattern where A and B differ, and a seeded model sweep covers the eight codes across many operand pairs.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int unsigned OP_ADD    = 0;
  localparam int unsigned OP_AND    = 1;
  localparam int unsigned OP_PASSA  = 2;
  localparam int unsigned OP_PASSB  = 3;
  localparam int unsigned OP_SUB    = 4;
  localparam int unsigned OP_INC    = 5;
  localparam int unsigned OP_ADDINC = 6;
  localparam int unsigned OP_SUBDEC = 7;

  typedef enum logic [1:0] {
    SRC_SUM = 2'd0,
    SRC_AND = 2'd1,
    SRC_A   = 2'd2,
    SRC_B   = 2'd3
  } src_e;

  typedef struct packed {
    logic invertB;   // feed ~B into the adder
    logic zeroB;     // feed 0 into the adder instead of B
    logic carryIn;   // adder carry-in
    logic carryEn;   // carry flag reflects adder bit 8
    src_e resultSrc; // 4-to-1 result selector
  } strobe_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
#(
  parameter int unsigned SelW = 5
) (
  input  logic [SelW-1:0] opSel,
  output strobe_t         strobe
);

  always_comb begin
    strobe = '{invertB: 1'b0, zeroB: 1'b0, carryIn: 1'b0,
               carryEn: 1'b0, resultSrc: SRC_A};
    case (opSel)
      SelW'(OP_ADD):    begin strobe.carryEn = 1'b1; strobe.resultSrc = SRC_SUM; end
      SelW'(OP_AND):    strobe.resultSrc = SRC_AND;
      SelW'(OP_PASSA):  strobe.resultSrc = SRC_A;
      SelW'(OP_PASSB):  strobe.resultSrc = SRC_B;
      SelW'(OP_SUB):    begin
        strobe.invertB = 1'b1; strobe.carryIn = 1'b1;
        strobe.carryEn = 1'b1; strobe.resultSrc = SRC_SUM;
      end
      SelW'(OP_INC):    begin
        strobe.zeroB = 1'b1; strobe.carryIn = 1'b1;
        strobe.carryEn = 1'b1; strobe.resultSrc = SRC_SUM;
      end
      SelW'(OP_ADDINC): begin
        strobe.carryIn = 1'b1; strobe.carryEn = 1'b1; strobe.resultSrc = SRC_SUM;
      end
      SelW'(OP_SUBDEC): begin
        strobe.invertB = 1'b1; strobe.carryEn = 1'b1; strobe.resultSrc = SRC_SUM;
      end
      default:          strobe.resultSrc = SRC_A; // R9: unused codes pass A
    endcase

    // R6 / R2: operand B is either inverted or dropped, never both
    assert_b_mode_excl_R6: assert (!(strobe.invertB && strobe.zeroB))
      else $error("invertB and zeroB both set");
    // R4 / R9: only adder-sourced results may raise carry
    assert_carry_src_R4: assert (!strobe.carryEn || strobe.resultSrc == SRC_SUM)
      else $error("carry enabled for non-adder source");
  end

endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int unsigned DataW = 8
) (
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  input  strobe_t          strobe,
  output logic [DataW-1:0] result,
  output logic             carryOut,
  output logic             zeroOut
);

  localparam int unsigned SumW = DataW + 1;

  logic [DataW-1:0] bOperand;
  logic [SumW-1:0]  sum;
  logic [DataW-1:0] andRes;

  always_comb begin
    if (strobe.zeroB)        bOperand = '0;
    else if (strobe.invertB) bOperand = ~opB;
    else                     bOperand = opB;

    sum    = {1'b0, opA} + {1'b0, bOperand} + SumW'(strobe.carryIn);
    andRes = opA & opB;

    case (strobe.resultSrc)
      SRC_SUM: result = sum[DataW-1:0];
      SRC_AND: result = andRes;
      SRC_A:   result = opA;
      default: result = opB;
    endcase

    carryOut = strobe.carryEn & sum[DataW];
    zeroOut  = (result == '0);

    assert_and_no_carry_R4: assert (strobe.resultSrc != SRC_AND || !carryOut)
      else $error("carry raised on AND");
    assert_inc_value_R6: assert (!strobe.zeroB || sum == {1'b0, opA} + SumW'(strobe.carryIn))
      else $error("increment path used B");
    assert_sub_value_R2: assert (!(strobe.invertB && strobe.carryIn)
                                 || sum[DataW-1:0] == DataW'(opA - opB))
      else $error("subtract path wrong");
    assert_zero_flag_R8: assert (!zeroOut || (strobe.resultSrc != SRC_A) || opA == '0)
      else $error("zero flag with nonzero A pass");
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned DataW = 8,
  parameter int unsigned SelW  = 5
) (
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  input  logic [SelW-1:0]  opSel,
  output logic [DataW-1:0] result,
  output logic             carryOut,
  output logic             zeroOut
);

  strobe_t strobe;

  flag_alu_ctrl #(.SelW(SelW)) u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  flag_alu_dp #(.DataW(DataW)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobe   (strobe),
    .result   (result),
    .carryOut (carryOut),
    .zeroOut  (zeroOut)
  );

endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;

  typedef struct packed {
    logic [4:0] sel;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    logic       c;
    logic       z;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{5'd0, 8'h10, 8'h20, 8'h30, 1'b0, 1'b0},  // R1
    '{5'd0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1},  // R1 R8
    '{5'd1, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0},  // R4
    '{5'd1, 8'h0F, 8'hF0, 8'h00, 1'b0, 1'b1},  // R4 R8
    '{5'd2, 8'h5A, 8'hA5, 8'h5A, 1'b0, 1'b0},  // R3
    '{5'd3, 8'h5A, 8'h00, 8'h00, 1'b0, 1'b1},  // R3 R8
    '{5'd4, 8'h64, 8'h0A, 8'h5A, 1'b1, 1'b0},  // R2
    '{5'd4, 8'h02, 8'h05, 8'hFD, 1'b0, 1'b0},  // R2
    '{5'd4, 8'h33, 8'h33, 8'h00, 1'b1, 1'b1},  // R2 R8
    '{5'd5, 8'hFF, 8'h77, 8'h00, 1'b1, 1'b1},  // R6
    '{5'd5, 8'h41, 8'hFF, 8'h42, 1'b0, 1'b0},  // R6
    '{5'd6, 8'h7F, 8'h80, 8'h00, 1'b1, 1'b1},  // R5
    '{5'd6, 8'h01, 8'h02, 8'h04, 1'b0, 1'b0},  // R5
    '{5'd7, 8'h05, 8'h05, 8'hFF, 1'b0, 1'b0},  // R7
    '{5'd7, 8'h09, 8'h03, 8'h05, 1'b1, 1'b0},  // R7
    '{5'd31, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1}  // R9 R8
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] opA = '0, opB = '0;
  logic [4:0] opSel = '0;
  logic [7:0] result;
  logic carryOut, zeroOut;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flag_alu u_flag_alu (
    .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .carryOut(carryOut), .zeroOut(zeroOut)
  );

  task automatic apply(input logic [4:0] s, input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    opSel = s; opA = a; opB = b;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] er, input logic ec, input logic ez);
    compared++;
    if (result !== er || carryOut !== ec || zeroOut !== ez) begin
      mismatched++;
      $display("FAIL %s sel=%0d a=%h b=%h: got res=%h c=%b z=%b, expected res=%h c=%b z=%b",
               req, opSel, opA, opB, result, carryOut, zeroOut, er, ec, ez);
    end
  endtask

  function automatic logic [9:0] model(input int s, input int a, input int b);
    int r, c;
    case (s)
      0: begin r = a + b;       c = (r > 255); end
      1: begin r = a & b;       c = 0; end
      3: begin r = b;           c = 0; end
      4: begin r = a - b;       c = (a >= b); end
      5: begin r = a + 1;       c = (a == 255); end
      6: begin r = a + b + 1;   c = (r > 255); end
      7: begin r = a - b - 1;   c = (a > b); end
      default: begin r = a;     c = 0; end
    endcase
    r = r & 255;
    model = {c[0], (r == 0), r[7:0]};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : main
    logic [9:0] exp;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Initial inputs are all zero: add of 0+0 gives 0, carry 0, zero 1 (R1 R8)
    @(negedge clk);
    check("R1_R8_initial", 8'h00, 1'b0, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].sel, VECS[i].a, VECS[i].b);
      check($sformatf("R1-vec%0d", i), VECS[i].res, VECS[i].c, VECS[i].z);
    end

    // R9: every unused code passes A, carry clear
    for (int s = 8; s < 32; s++) begin
      apply(5'(s), 8'hC3, 8'h3C);
      check("R9_unused", 8'hC3, 1'b0, 1'b0);
    end

    // R6: B has no effect on increment
    for (int bb = 0; bb < 256; bb += 51) begin
      apply(5'd5, 8'h7E, 8'(bb));
      check("R6_ignoreB", 8'h7F, 1'b0, 1'b0);
    end

    // R2 R7 boundary: equal operands and A one above B
    apply(5'd7, 8'h81, 8'h80); check("R7_gt", 8'h00, 1'b1, 1'b1);
    apply(5'd4, 8'h00, 8'h00); check("R2_eq0", 8'h00, 1'b1, 1'b1);
    apply(5'd4, 8'h00, 8'hFF); check("R2_borrow", 8'h01, 1'b0, 1'b0);

    // Model sweep R1 R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < 400; k++) begin
      int s, a, b;
      s = k % 8;
      a = (k * 37 + 11) & 255;
      b = (k * 91 + 200) & 255;
      exp = model(s, a, b);
      apply(5'(s), 8'(a), 8'(b));
      check("R8_sweep", exp[7:0], exp[9], exp[8]);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule